// File: doc/BRIEF.md
# Software Interrupt Entry and Return Sequencer

This block carries out the context save and restore for the two software exception opcodes and for return-from-interrupt in a 16-bit accumulator CPU core. The core has two modes. In emulation mode the stack is held to one fixed page and the program bank stays where it is. In native mode the program bank is saved with the rest of the frame and is then cleared. The core sends an opcode strobe together with its current PC, program bank, status and stack pointer. The block then does one stack memory access per cycle and returns the updated register values, a done pulse and the instruction's cycle cost.

Entry pushes the return address (opcode address plus two, so that the signature byte is skipped) and the status byte. It then sets interrupt-disable, clears decimal mode and loads the PC from the vector that matches the opcode and the mode. Return-from-interrupt reverses the frame. The register outputs are valid in the cycle that `done` is high.

Top module: `swi_seq`

## Requirements
- R1: Only the opcodes 0x00 (break), 0x02 (coprocessor) and 0x40 (return) are accepted. Any other code, or any strobe while `busy` is high, causes no memory access and changes no output.
- R2: On entry the saved PC is `pc_in`+2. The high byte of a 16-bit value is pushed before the low byte. Each push writes at S and then decrements S.
- R3: An emulation-mode entry writes three bytes in the order PC high, PC low, status. `pbr_out` keeps `pbr_in`.
- R4: A native-mode entry writes four bytes in the order bank, PC high, PC low, status, and then sets `pbr_out` to 0x00.
- R5: After entry, `p_out` has bit 2 (interrupt disable) set and bit 3 (decimal) cleared, and every other bit is unchanged. The pushed status byte is `p_in` unmodified, so no break bit is forced on.
- R6: The new PC is `vec_brk_emu`/`vec_brk_nat` for break and `vec_cop_emu`/`vec_cop_nat` for coprocessor, chosen by the mode.
- R7: Return increments S and then reads at the new S, in the order status, PC low, PC high, and then the bank in native mode only. In emulation mode `pbr_out` keeps `pbr_in`.
- R8: With `done`, `cycles` reports 7 for emulation entry, 8 for native entry, 6 for emulation return and 7 for native return.
- R9: `busy` is high from the edge that accepts a strobe. `done` pulses for one cycle, with `busy` low, in the cycle after the last memory access. That gives 3 accesses in emulation mode and 4 in native mode.
- R10: In emulation mode every stack address has the high byte 0x01. `s_in[15:8]` is ignored and the low byte wraps within the page. `s_out` is the final stack pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Opcode strobe |
| op_code | input | 8 | Opcode byte |
| emu | input | 1 | 1 = emulation mode, 0 = native mode |
| pc_in | input | 16 | Address of the opcode |
| pbr_in | input | 8 | Program bank in |
| p_in | input | 8 | Status byte in |
| s_in | input | 16 | Stack pointer in |
| vec_brk_emu | input | 16 | Break vector, emulation mode |
| vec_brk_nat | input | 16 | Break vector, native mode |
| vec_cop_emu | input | 16 | Coprocessor vector, emulation mode |
| vec_cop_nat | input | 16 | Coprocessor vector, native mode |
| mem_we | output | 1 | Stack write strobe |
| mem_re | output | 1 | Stack read strobe |
| mem_addr | output | 16 | Stack address |
| mem_wdata | output | 8 | Stack write byte |
| mem_rdata | input | 8 | Stack read byte, same cycle as the address |
| pc_out | output | 16 | Resulting PC |
| pbr_out | output | 8 | Resulting program bank |
| p_out | output | 8 | Resulting status |
| s_out | output | 16 | Resulting stack pointer |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| cycles | output | 4 | Cycle cost of the finished instruction |

## Verification
The bench builds the block with its default parameters: opcodes 0x00, 0x02 and 0x40, emulation page 0x01 and a return step of 2. With these values it can compare every frame byte and address against the instruction-level rules. Directed cases place the emulation stack pointer at 0x0100 and 0x01FE, so that the page wrap is exercised in both directions. They also run an entry followed by a return as a round trip, send an undefined opcode, and strobe again while a sequence is in progress. Seeded random runs vary the mode, the opcode, the register values, the vectors and the stack contents.

// File: rtl/swi_seq.sv
module swi_seq #(
  parameter logic [7:0] OP_BRK   = 8'h00,
  parameter logic [7:0] OP_COP   = 8'h02,
  parameter logic [7:0] OP_RTI   = 8'h40,
  parameter logic [7:0] EMU_PAGE = 8'h01,
  parameter int         PC_SKIP  = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        op_valid,
  input  logic [7:0]  op_code,
  input  logic        emu,
  input  logic [15:0] pc_in,
  input  logic [7:0]  pbr_in,
  input  logic [7:0]  p_in,
  input  logic [15:0] s_in,
  input  logic [15:0] vec_brk_emu,
  input  logic [15:0] vec_brk_nat,
  input  logic [15:0] vec_cop_emu,
  input  logic [15:0] vec_cop_nat,
  output logic        mem_we,
  output logic        mem_re,
  output logic [15:0] mem_addr,
  output logic [7:0]  mem_wdata,
  input  logic [7:0]  mem_rdata,
  output logic [15:0] pc_out,
  output logic [7:0]  pbr_out,
  output logic [7:0]  p_out,
  output logic [15:0] s_out,
  output logic        busy,
  output logic        done,
  output logic [3:0]  cycles
);
  localparam logic [7:0]  FLAG_I = 8'h04;
  localparam logic [7:0]  FLAG_D = 8'h08;
  localparam logic [15:0] SKIP   = 16'(PC_SKIP);

  logic        busy_q, rti_q, nat_q, done_q;
  logic [1:0]  step_q;
  logic [15:0] pc_q, sp_q, vec_q;
  logic [7:0]  pbr_q, p_q;
  logic [3:0]  cyc_q;

  wire known = (op_code == OP_BRK) || (op_code == OP_COP) || (op_code == OP_RTI);
  wire accept = op_valid && !busy_q && known;
  wire [1:0] last = nat_q ? 2'd3 : 2'd2;
  wire [1:0] idx = rti_q ? step_q : step_q + {1'b0, ~nat_q};
  wire [15:0] sp_dn = nat_q ? sp_q - 16'd1 : {EMU_PAGE, sp_q[7:0] - 8'd1};
  wire [15:0] sp_up = nat_q ? sp_q + 16'd1 : {EMU_PAGE, sp_q[7:0] + 8'd1};
  wire [15:0] vec_sel = (op_code == OP_COP) ? (emu ? vec_cop_emu : vec_cop_nat)
                                            : (emu ? vec_brk_emu : vec_brk_nat);

  assign mem_we   = busy_q && !rti_q;
  assign mem_re   = busy_q && rti_q;
  assign mem_addr = rti_q ? sp_up : sp_q;

  always_comb begin
    case (idx)
      2'd0:    mem_wdata = pbr_q;
      2'd1:    mem_wdata = pc_q[15:8];
      2'd2:    mem_wdata = pc_q[7:0];
      default: mem_wdata = p_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      rti_q  <= 1'b0;
      nat_q  <= 1'b0;
      done_q <= 1'b0;
      step_q <= 2'd0;
      pc_q   <= 16'd0;
      sp_q   <= 16'd0;
      vec_q  <= 16'd0;
      pbr_q  <= 8'd0;
      p_q    <= 8'd0;
      cyc_q  <= 4'd0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        busy_q <= 1'b1;
        rti_q  <= (op_code == OP_RTI);
        nat_q  <= !emu;
        step_q <= 2'd0;
        pc_q   <= pc_in + SKIP;
        sp_q   <= emu ? {EMU_PAGE, s_in[7:0]} : s_in;
        vec_q  <= vec_sel;
        pbr_q  <= pbr_in;
        p_q    <= p_in;
      end else if (busy_q) begin
        step_q <= step_q + 2'd1;
        sp_q   <= rti_q ? sp_up : sp_dn;
        if (rti_q) begin
          case (step_q)
            2'd0:    p_q        <= mem_rdata;
            2'd1:    pc_q[7:0]  <= mem_rdata;
            2'd2:    pc_q[15:8] <= mem_rdata;
            default: pbr_q      <= mem_rdata;
          endcase
        end
        if (step_q == last) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          cyc_q  <= (rti_q ? 4'd6 : 4'd7) + {3'd0, nat_q};
          if (!rti_q) begin
            pc_q <= vec_q;
            p_q  <= (p_q | FLAG_I) & ~FLAG_D;
            if (nat_q) pbr_q <= 8'd0;
          end
        end
      end
    end
  end

  assign pc_out  = pc_q;
  assign pbr_out = pbr_q;
  assign p_out   = p_q;
  assign s_out   = sp_q;
  assign busy    = busy_q;
  assign done    = done_q;
  assign cycles  = cyc_q;

  assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_cycle_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cycles >= 4'd6 && cycles <= 4'd8));
  assert_emu_page_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !nat_q) |-> mem_addr[15:8] == EMU_PAGE);
  assert_push_dec_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && nat_q) |=> s_out == $past(s_out) - 16'd1);
  assert_pop_inc_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |=> s_out == $past(mem_addr));
  assert_entry_flags_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $past(mem_we)) |-> (p_out[2] && !p_out[3]));
  assert_native_bank_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $past(mem_we) && nat_q) |-> pbr_out == 8'h00);
  assert_access_excl_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re));
endmodule

// File: tb/tb_swi_seq.sv
module tb_swi_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic op_valid = 1'b0;
  logic [7:0] op_code = 8'h00;
  logic emu = 1'b1;
  logic [15:0] pc_in = 16'd0, s_in = 16'd0;
  logic [7:0] pbr_in = 8'd0, p_in = 8'd0;
  logic [15:0] vbe = 16'd0, vbn = 16'd0, vce = 16'd0, vcn = 16'd0;
  logic mem_we, mem_re, busy, done;
  logic [15:0] mem_addr, pc_out, s_out;
  logic [7:0] mem_wdata, mem_rdata, pbr_out, p_out;
  logic [3:0] cycles;

  always #2.5 clk = ~clk;

  swi_seq dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code), .emu(emu),
    .pc_in(pc_in), .pbr_in(pbr_in), .p_in(p_in), .s_in(s_in),
    .vec_brk_emu(vbe), .vec_brk_nat(vbn), .vec_cop_emu(vce), .vec_cop_nat(vcn),
    .mem_we(mem_we), .mem_re(mem_re), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .pc_out(pc_out), .pbr_out(pbr_out), .p_out(p_out),
    .s_out(s_out), .busy(busy), .done(done), .cycles(cycles)
  );

  logic [7:0] mem [0:1023];
  logic [15:0] wa [0:7];
  logic [7:0] wd [0:7];
  int wn = 0, rn = 0;
  int nchk = 0, nerr = 0;

  assign mem_rdata = mem[mem_addr[9:0]];

  always @(posedge clk) begin
    if (mem_we) begin
      mem[mem_addr[9:0]] <= mem_wdata;
      if (wn < 8) begin wa[wn] <= mem_addr; wd[wn] <= mem_wdata; end
      wn <= wn + 1;
    end
    if (mem_re) rn <= rn + 1;
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_flags(input logic [7:0] p);
    return (p | 8'h04) & ~8'h08;
  endfunction

  function automatic logic [15:0] stk(input bit e, input logic [15:0] s, input int k);
    return e ? {8'h01, s[7:0] + 8'(k)} : s + 16'(k);
  endfunction

  task automatic run(input logic [7:0] code, input bit e, input logic [15:0] pc,
                     input logic [7:0] pbr, input logic [7:0] p, input logic [15:0] s,
                     input bit poke);
    int cnt;
    int n;
    logic [7:0] b [0:3];
    logic [15:0] pc2;
    logic [15:0] vec;
    n = e ? 3 : 4;
    pc2 = pc + 16'd2;
    @(negedge clk);
    if (code == 8'h40) begin
      for (int k = 1; k <= 4; k++) begin
        b[k-1] = 8'($urandom);
        mem[stk(e, s, k) & 16'h03FF] = b[k-1];
      end
    end
    op_code = code; emu = e; pc_in = pc; pbr_in = pbr; p_in = p; s_in = s;
    op_valid = 1'b1;
    wn = 0; rn = 0;
    @(negedge clk);
    op_valid = 1'b0;
    cnt = 0;
    while (!done && cnt < 40) begin
      @(negedge clk);
      cnt++;
      if (poke && cnt == 1) begin op_valid = 1'b1; op_code = 8'h02; end
      else op_valid = 1'b0;
    end
    op_code = code;
    if (cnt >= 40) check("watchdog R9", 32'(cnt), 32'(n));
    check("R9 done after last access", 32'(cnt), 32'(n));
    check("R9 busy low with done", {31'd0, busy}, 32'd0);
    if (code == 8'h40) begin
      check("R8 return cycles", {28'd0, cycles}, e ? 32'd6 : 32'd7);
      check("R7 no writes on return", 32'(wn), 32'd0);
      check("R7 read count", 32'(rn), 32'(n));
      check("R7 status popped", {24'd0, p_out}, {24'd0, b[0]});
      check("R7 pc popped", {16'd0, pc_out}, {16'd0, b[2], b[1]});
      check("R7 bank", {24'd0, pbr_out}, {24'd0, e ? pbr : b[3]});
      check("R10 return sp", {16'd0, s_out}, {16'd0, stk(e, s, n)});
    end else begin
      if (code == 8'h02) vec = e ? vce : vcn;
      else vec = e ? vbe : vbn;
      if (e) begin b[0] = pc2[15:8]; b[1] = pc2[7:0]; b[2] = p; end
      else begin b[0] = pbr; b[1] = pc2[15:8]; b[2] = pc2[7:0]; b[3] = p; end
      check("R8 entry cycles", {28'd0, cycles}, e ? 32'd7 : 32'd8);
      check(e ? "R3 write count" : "R4 write count", 32'(wn), 32'(n));
      for (int k = 0; k < n; k++) begin
        check("R10 R2 push address", {16'd0, wa[k]}, {16'd0, stk(e, s, -k)});
        check(e ? "R3 R2 frame byte" : "R4 R2 frame byte", {24'd0, wd[k]}, {24'd0, b[k]});
      end
      check("R6 vector", {16'd0, pc_out}, {16'd0, vec});
      check("R5 flags", {24'd0, p_out}, {24'd0, exp_flags(p)});
      check(e ? "R3 bank kept" : "R4 bank cleared", {24'd0, pbr_out}, e ? {24'd0, pbr} : 32'd0);
      check("R10 entry sp", {16'd0, s_out}, {16'd0, stk(e, s, -n)});
    end
  endtask

  initial begin
    logic [15:0] spc;
    logic [7:0] sp8;
    void'($urandom(32'd20240917));
    for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    check("reset busy R9", {31'd0, busy}, 32'd0);
    check("reset done R9", {31'd0, done}, 32'd0);
    check("reset we R1", {31'd0, mem_we}, 32'd0);
    check("reset pc R1", {16'd0, pc_out}, 32'd0);
    rst_n = 1'b1;
    vbe = 16'hFFE6; vbn = 16'hFFE4; vce = 16'h0123; vcn = 16'h0456;

    run(8'h02, 1'b1, 16'h0156, 8'h15, 8'h0F, 16'h01FF, 1'b0);
    run(8'h02, 1'b0, 16'h0156, 8'h15, 8'hF1, 16'h1FFF, 1'b0);
    run(8'h00, 1'b1, 16'hFFFF, 8'h3C, 8'h08, 16'h5500, 1'b0);
    run(8'h00, 1'b0, 16'h1234, 8'h7E, 8'hFF, 16'h0002, 1'b0);
    run(8'h40, 1'b1, 16'h0000, 8'h22, 8'h00, 16'h01FE, 1'b0);
    run(8'h40, 1'b0, 16'h0000, 8'h44, 8'h00, 16'h03FC, 1'b0);
    run(8'h02, 1'b0, 16'h2000, 8'h09, 8'h33, 16'h0300, 1'b1);

    // R1 round trip: native entry then return restores the frame
    run(8'h00, 1'b0, 16'hABCD, 8'h5A, 8'hC3, 16'h0200, 1'b0);
    spc = s_out;
    @(negedge clk);
    op_code = 8'h40; emu = 1'b0; s_in = spc; op_valid = 1'b1;
    @(negedge clk); op_valid = 1'b0;
    while (!done) @(negedge clk);
    check("R7 round pc", {16'd0, pc_out}, 32'h0000ABCF);
    check("R7 round status", {24'd0, p_out}, 32'h000000C3);
    check("R7 round bank", {24'd0, pbr_out}, 32'h0000005A);
    check("R7 round sp", {16'd0, s_out}, 32'h00000200);

    // R1 undefined opcode is ignored
    spc = pc_out; sp8 = p_out;
    @(negedge clk);
    op_code = 8'h01; op_valid = 1'b1; wn = 0; rn = 0;
    @(negedge clk); op_valid = 1'b0;
    repeat (5) @(negedge clk);
    check("R1 ignored busy", {31'd0, busy}, 32'd0);
    check("R1 ignored access", 32'(wn + rn), 32'd0);
    check("R1 ignored pc", {16'd0, pc_out}, {16'd0, spc});
    check("R1 ignored status", {24'd0, p_out}, {24'd0, sp8});

    for (int i = 0; i < 40; i++) begin
      logic [7:0] c;
      logic e;
      case ($urandom % 3) 0: c = 8'h00; 1: c = 8'h02; default: c = 8'h40; endcase
      e = 1'($urandom);
      vbe = 16'($urandom); vbn = 16'($urandom); vce = 16'($urandom); vcn = 16'($urandom);
      run(c, e, 16'($urandom), 8'($urandom), 8'($urandom), 16'($urandom), 1'($urandom));
    end

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    #200000;
    nchk++; nerr++;
    $display("FAIL watchdog R9 act=timeout exp=finish");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule